// File: doc/BRIEF.md
# Six-Channel PWM Controller with Triggered Settings Hand-Over

This block generates six independent pulse-width-modulated outputs from one clock. Each channel counts in ticks of the clock divided by (prescale + 1). Its period is a 24-bit count of ticks and its active time is a second 24-bit count. A polarity bit selects whether the active part of the period drives the output high or low. Software reaches the block through a small synchronous register bus with an address, write data, a write strobe and registered read data.

Bus writes land only in a staging copy of the settings. A channel moves its staging copy into the set that drives its waveform only when software raises that channel's trigger bit from 0 to 1. The per-channel smooth bit, sampled at that edge, chooses the hand-over point. With smooth set, the switch happens at the end of the running period. With smooth clear, the switch happens after a fixed delay of `IMM_DLY` clocks. When a new set is loaded, the tick and period counters start again from zero. A channel whose trigger and smooth bits are both 0 drives a constant high level. The block has no enable bit: a zero active count parks the output at its inactive level.

Top module: `trigpwm_top`

## Requirements
- R1: After reset all staging registers and the control register read 0, and every output is high.
- R2: Address 0x00 holds per-channel control fields: trigger at bit n, polarity at bit 8+n, output type at bit 16+n, smooth at bit 24+n. Address 0x04 holds a 3-bit prescale for channel n at bits 4n+2..4n. The period count is at 0x08+8n and the active count at 0x0C+8n, each 24 bits wide. Reads return the staging values one clock after the address is presented, and bits with no field read as 0.
- R3: Writes to prescale, period, active count or polarity do not change a running waveform until that channel's trigger bit rises.
- R4: With smooth at 0 when the trigger rises, the new settings drive the output from the 21st rising clock edge after the edge that wrote the trigger bit (`IMM_DLY` = 20), with counters restarted.
- R5: With smooth at 1 when the trigger rises, the old waveform continues and the new settings take over at the first period boundary after the capture, with counters restarted.
- R6: A channel whose trigger and smooth bits are both 0 outputs a constant high, from the clock edge that writes those values.
- R7: A loaded channel repeats a period of (prescale+1)*PC clocks and is active during the first (prescale+1)*DC clocks of each period.
- R8: Polarity 1 makes the active level high and polarity 0 makes it low. A loaded active count of 0 holds the output at the inactive level.
- R9: An active count greater than or equal to the period count keeps the output active for the whole period.
- R10: Triggering or reconfiguring one channel leaves every other channel's waveform unchanged.
- R11: The output-type bits are stored and read back but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus, the counters and the outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register to read or write |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_rdata | output | 32 | Staging value at the address presented in the previous cycle |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
The assertions assume the prescale never changes under a running channel except through a load. They also assume that a write strobe carries a stable address for its cycle and that the reset is held long enough to clear every register. The stimulus drives the bus only on falling clock edges and issues one register access at a time. It raises a trigger only after the matching staging registers are written. Every rise of a trigger bit is preceded by a write that leaves the bit at 0, so each rise is a single, well-defined edge.

// File: rtl/trigpwm_pkg.sv
package trigpwm_pkg;
    localparam int CNT_W = 24;
    localparam int PS_W  = 3;

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] pc;
        logic [CNT_W-1:0] dc;
        logic             pol;
    } chan_cfg_t;
endpackage

// File: rtl/trigpwm_regs.sv
module trigpwm_regs
    import trigpwm_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic                  we,
    output logic [DW-1:0]         rdata,
    output chan_cfg_t [NCH-1:0]   cfg,
    output logic [NCH-1:0]        trig,
    output logic [NCH-1:0]        smooth
);
    localparam int CTRL_ADDR  = 0;
    localparam int PS_ADDR    = 4;
    localparam int CNT_BASE   = 8;
    localparam int CNT_STRIDE = 8;
    localparam int DC_OFS     = 4;
    localparam int POL_LSB    = 8;
    localparam int TYPE_LSB   = 16;
    localparam int SMOOTH_LSB = 24;
    localparam int PS_STRIDE  = 4;

    typedef struct packed {
        logic [NCH-1:0]            trig;
        logic [NCH-1:0]            pol;
        logic [NCH-1:0]            otype;
        logic [NCH-1:0]            smooth;
        logic [NCH-1:0][PS_W-1:0]  ps;
        logic [NCH-1:0][CNT_W-1:0] pc;
        logic [NCH-1:0][CNT_W-1:0] dc;
        logic [DW-1:0]             rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  cnt_hit;

    always_comb begin
        logic [DW-1:0] rd;
        st_d    = st_q;
        rd      = '0;
        cnt_hit = 1'b0;
        if (addr == AW'(CTRL_ADDR)) begin
            for (int n = 0; n < NCH; n++) begin
                rd[n]            = st_q.trig[n];
                rd[POL_LSB+n]    = st_q.pol[n];
                rd[TYPE_LSB+n]   = st_q.otype[n];
                rd[SMOOTH_LSB+n] = st_q.smooth[n];
                if (we) begin
                    st_d.trig[n]   = wdata[n];
                    st_d.pol[n]    = wdata[POL_LSB+n];
                    st_d.otype[n]  = wdata[TYPE_LSB+n];
                    st_d.smooth[n] = wdata[SMOOTH_LSB+n];
                end
            end
        end
        if (addr == AW'(PS_ADDR)) begin
            for (int n = 0; n < NCH; n++) begin
                rd[PS_STRIDE*n +: PS_W] = st_q.ps[n];
                if (we) st_d.ps[n] = wdata[PS_STRIDE*n +: PS_W];
            end
        end
        for (int n = 0; n < NCH; n++) begin
            if (addr == AW'(CNT_BASE + CNT_STRIDE*n)) begin
                rd[CNT_W-1:0] = st_q.pc[n];
                cnt_hit       = 1'b1;
                if (we) st_d.pc[n] = wdata[CNT_W-1:0];
            end
            if (addr == AW'(CNT_BASE + CNT_STRIDE*n + DC_OFS)) begin
                rd[CNT_W-1:0] = st_q.dc[n];
                cnt_hit       = 1'b1;
                if (we) st_d.dc[n] = wdata[CNT_W-1:0];
            end
        end
        st_d.rdata = rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            cfg[n].ps  = st_q.ps[n];
            cfg[n].pc  = st_q.pc[n];
            cfg[n].dc  = st_q.dc[n];
            cfg[n].pol = st_q.pol[n];
        end
    end

    assign rdata  = st_q.rdata;
    assign trig   = st_q.trig;
    assign smooth = st_q.smooth;

    // R2
    count_rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit |=> rdata[DW-1:CNT_W] == '0);
endmodule

// File: rtl/trigpwm_chan.sv
module trigpwm_chan
    import trigpwm_pkg::*;
#(
    parameter int IMM_DLY = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t stage,
    input  logic      trig,
    input  logic      smooth,
    output logic      wave
);
    localparam int DLY_W = (IMM_DLY > 1) ? $clog2(IMM_DLY) : 1;

    typedef struct packed {
        chan_cfg_t        act;
        chan_cfg_t        pend;
        logic             pend_v;
        logic             pend_sm;
        logic             trig_prev;
        logic [DLY_W-1:0] dly;
        logic [PS_W-1:0]  tcnt;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    chan_st_t       st_d, st_q;
    logic           rise, tick_end, per_end, load;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        rise     = trig & ~st_q.trig_prev;
        tick_end = (st_q.tcnt == st_q.act.ps);
        cnt_inc  = {1'b0, st_q.cnt} + 1'b1;
        per_end  = tick_end && (cnt_inc >= {1'b0, st_q.act.pc});
        load     = st_q.pend_v && (st_q.pend_sm ? per_end : (st_q.dly == '0));

        st_d           = st_q;
        st_d.trig_prev = trig;

        if (tick_end) begin
            st_d.tcnt = '0;
            st_d.cnt  = per_end ? '0 : cnt_inc[CNT_W-1:0];
        end else begin
            st_d.tcnt = st_q.tcnt + 1'b1;
        end

        if (load) begin
            st_d.act    = st_q.pend;
            st_d.pend_v = 1'b0;
            st_d.tcnt   = '0;
            st_d.cnt    = '0;
        end

        if (rise) begin
            st_d.pend    = stage;
            st_d.pend_v  = 1'b1;
            st_d.pend_sm = smooth;
            st_d.dly     = DLY_W'(IMM_DLY - 1);
        end else if (st_q.pend_v && !st_q.pend_sm && st_q.dly != '0) begin
            st_d.dly = st_q.dly - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave = st_q.act.pol ? (st_q.cnt < st_q.act.dc) : ~(st_q.cnt < st_q.act.dc);

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.act));
    // R4
    imm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_v && !st_q.pend_sm && st_q.dly != '0 && !rise) |=> st_q.pend_v);
    // R5
    smooth_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_v && st_q.pend_sm && !per_end && !rise) |=> st_q.pend_v);
    // R7
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act.pc != '0) |-> (st_q.cnt < st_q.act.pc));
    // R7
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tcnt <= st_q.act.ps);
endmodule

// File: rtl/trigpwm_top.sv
module trigpwm_top
    import trigpwm_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int IMM_DLY = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_we,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    chan_cfg_t [NCH-1:0] stage_cfg;
    logic [NCH-1:0]      trig, smooth, wave;

    trigpwm_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (bus_we),
        .rdata  (bus_rdata),
        .cfg    (stage_cfg),
        .trig   (trig),
        .smooth (smooth)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        trigpwm_chan #(.IMM_DLY(IMM_DLY)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .stage  (stage_cfg[n]),
            .trig   (trig[n]),
            .smooth (smooth[n]),
            .wave   (wave[n])
        );
        assign pwm_out[n] = (~trig[n] & ~smooth[n]) | wave[n];
    end
endmodule

// File: tb/tb_trigpwm_top.sv
module tb_trigpwm_top;
    localparam int NCH = 6, AW = 8, DW = 32, IMM = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  wdata;
    logic           we;
    logic [DW-1:0]  rdata;
    logic [NCH-1:0] pwm;

    trigpwm_top #(.NCH(NCH), .AW(AW), .DW(DW), .IMM_DLY(IMM)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_rdata(rdata), .pwm_out(pwm)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [DW-1:0] ctrl_sh;

    typedef struct { int at; int ch; logic val; string tag; } exp_t;
    exp_t sb[$];

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            if (e.at != cyc) chk({e.tag, " (missed cycle)"}, 0, 1);
            else             chk(e.tag, {31'b0, pwm[e.ch]}, {31'b0, e.val});
        end
    end

    task automatic push(int ch, int at, logic val, string tag);
        exp_t e;
        e.at = at; e.ch = ch; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    function automatic logic wave_exp(int k, int ps, int pc, int dc, int pol);
        int  ph;
        logic a;
        ph = (pc == 0) ? 0 : (k / (ps + 1)) % pc;
        a  = (ph < dc);
        return (pol != 0) ? a : !a;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int t, l0, lb, l1, l2, e;
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; ctrl_sh = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs high after reset", {26'b0, pwm}, 32'h3f);
        rd_chk(8'h00, 32'h0, "R1 control reset");
        rd_chk(8'h04, 32'h0, "R1 prescale reset");
        rd_chk(8'h08, 32'h0, "R1 period ch0 reset");

        wr(8'h10, 32'hABCDEF12);
        rd_chk(8'h10, 32'h00CDEF12, "R2 period ch1 24-bit");
        wr(8'h34, 32'h00000123);
        rd_chk(8'h34, 32'h00000123, "R2 active count ch5");
        wr(8'h04, 32'hFFFFFFFF);
        rd_chk(8'h04, 32'h00777777, "R2 prescale fields");
        wr(8'h00, 32'hC0FF0000);
        rd_chk(8'h00, 32'h003F0000, "R11 output type readback");
        chk("R11 output type no effect", {26'b0, pwm}, 32'h3f);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);

        // R4: immediate load on ch0 (ps 0, pc 4, dc 1, polarity 1)
        wr(8'h08, 4);
        wr(8'h0C, 1);
        ctrl_sh = 32'h0000_0100;
        wr(8'h00, ctrl_sh);
        chk("R6 forced high before trigger", {31'b0, pwm[0]}, 32'h1);
        ctrl_sh |= 32'h1;
        wr(8'h00, ctrl_sh);
        t = cyc; l0 = t + IMM + 1;
        for (int at = t + 1; at <= l0 + 11; at++)
            push(0, at, (at < l0) ? 1'b1 : wave_exp(at - l0, 0, 4, 1, 1), "R4 R7 immediate load");
        drain();

        // R3: staging write with no trigger edge
        wr(8'h0C, 3);
        t = cyc;
        for (int at = t + 1; at <= t + 12; at++)
            push(0, at, wave_exp(at - l0, 0, 4, 1, 1), "R3 staged write ignored");
        drain();

        // R5: smooth hand-over to pc 6, dc 3
        wr(8'h08, 6);
        ctrl_sh = 32'h0100_0100;
        wr(8'h00, ctrl_sh);
        ctrl_sh |= 32'h1;
        wr(8'h00, ctrl_sh);
        t = cyc; e = t + 2;
        while (((e - l0) % 4) != 0) e++;
        lb = e;
        for (int at = t + 1; at <= lb + 13; at++)
            push(0, at, (at < lb) ? wave_exp(at - l0, 0, 4, 1, 1) : wave_exp(at - lb, 0, 6, 3, 1),
                 "R5 smooth boundary load");
        drain();

        // R7 R8 R10: ch1 prescaled and inverted, ch0 keeps running
        wr(8'h10, 3);
        wr(8'h14, 1);
        wr(8'h04, 32'h20);
        ctrl_sh |= 32'h2;
        wr(8'h00, ctrl_sh);
        t = cyc; l1 = t + IMM + 1;
        for (int at = t + 1; at <= l1 + 20; at++) begin
            push(1, at, (at < l1) ? 1'b1 : wave_exp(at - l1, 2, 3, 1, 0), "R7 R8 prescaled inverted");
            push(0, at, wave_exp(at - lb, 0, 6, 3, 1), "R10 ch0 unaffected");
        end
        drain();

        // R8 zero active count on ch2, R9 active count equal to period on ch3
        wr(8'h18, 5);
        wr(8'h1C, 0);
        wr(8'h20, 3);
        wr(8'h24, 3);
        ctrl_sh |= 32'h0000_0400;
        wr(8'h00, ctrl_sh);
        ctrl_sh |= 32'h0000_000C;
        wr(8'h00, ctrl_sh);
        t = cyc; l2 = t + IMM + 1;
        for (int at = t + 1; at <= l2 + 8; at++) begin
            push(2, at, (at < l2) ? 1'b1 : 1'b0, "R8 zero active count");
            push(3, at, (at < l2) ? 1'b1 : 1'b0, "R9 full-period active");
        end
        drain();

        // R6: ch2 back to idle high
        ctrl_sh &= ~32'h4;
        wr(8'h00, ctrl_sh);
        chk("R6 idle high", {31'b0, pwm[2]}, 32'h1);
        chk("R10 ch3 unaffected", {31'b0, pwm[3]}, 32'h0);

        // R11: output type bits with running waveforms
        ctrl_sh |= 32'h003F_0000;
        wr(8'h00, ctrl_sh);
        t = cyc;
        for (int at = t + 1; at <= t + 12; at++)
            push(1, at, wave_exp(at - l1, 2, 3, 1, 0), "R11 output type no effect");
        drain();
        rd_chk(8'h00, ctrl_sh, "R2 R11 control readback");

        done = 1'b1;
        finish_run();
    end
endmodule